// File: doc/BRIEF.md
# Receive Destination Address Screen

This block decides, for each received frame, whether the frame's 48-bit destination address is wanted. An address can pass in four ways: by equality with either of two programmable station addresses, by being the all-ones broadcast address, or by landing on a set bit of a 64-entry group table. The group table is indexed by a 6-bit XOR fold of the whole address, so it acts as a single-hash Bloom filter. Frames too short to carry a full header are always refused.

Frame descriptors (destination plus byte length) arrive on a valid/ready stream. Decisions leave on a second valid/ready stream, one cycle after the descriptor is taken. The input is ready whenever the one-entry output stage is empty or is being drained in that same cycle. While `dec_valid` is high and `dec_ready` is low, the decision and hash stay frozen and `frm_ready` stays low. The station addresses and the group table live inside the block and are loaded through a simple word write port. The four mode bits are plain level inputs.

Top module: `rx_addr_screen`

## Requirements
- R1: A frame whose `frm_len` is below 12 is refused (`dec_accept`=0), whatever its address and the mode bits.
- R2: With `mode[0]` set, a frame of length 12 or more whose destination equals station address 0 is accepted. With `mode[0]` clear, that equality does not cause acceptance.
- R3: With `mode[1]` set, a frame of length 12 or more whose destination equals station address 1 is accepted. With `mode[1]` clear, that equality does not cause acceptance.
- R4: With `mode[3]` set, a frame of length 12 or more whose destination is all ones is accepted.
- R5: `dec_hash` carries, for every frame, the XOR of the eight 6-bit slices `frm_dest[6g+5:6g]` (g = 0..7). Byte 0 of the address sits in `frm_dest[7:0]`. The hash is reported even when the group check does not apply.
- R6: The group check passes when table bit `dec_hash` is set. Index 0..31 selects bit `index` of the low table word; index 32..63 selects bit `index-32` of the high table word.
- R7: With `mode[2]` clear, only destinations whose multicast bit `frm_dest[0]` is 1 may pass the group check. With `mode[2]` set, any destination may pass it.
- R8: `cfg_we` stores `cfg_wdata` in the word chosen by `cfg_sel`: 0 = station 0 bytes 0..3, 1 = station 0 bytes 4..5, 2 = station 1 bytes 0..3, 3 = station 1 bytes 4..5, 4 = table bits 0..31, 5 = table bits 32..63. Codes 6 and 7 write nothing. In a bytes 0..3 word, byte 0 is bits 7:0. In a bytes 4..5 word, byte 4 is bits 7:0, byte 5 is bits 15:8, and bits 31:16 are ignored.
- R9: A descriptor taken on `frm_valid && frm_ready` yields `dec_valid` with its decision after exactly one clock edge. `frm_ready` equals `!dec_valid || dec_ready`. A stalled decision holds its values.
- R10: After reset, `dec_valid` is 0, and both station addresses and the whole table are zero.
- R11: A configuration write and a frame taken in the same cycle: the frame is judged on the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 4 | Bit 0 station 0 enable, bit 1 station 1 enable, bit 2 hash on individual addresses, bit 3 broadcast enable |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| frm_valid | input | 1 | Frame descriptor valid |
| frm_ready | output | 1 | Frame descriptor accepted this cycle |
| frm_dest | input | 48 | Destination address, byte 0 in bits 7:0 |
| frm_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Decision consumer ready |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |
| dec_hash | output | 6 | Group hash index of the judged address |

## Verification
A configuration write and a frame evaluation can occur in the same cycle. The bench provokes this by rewriting station address 0 on the same edge that takes a frame addressed to its old value. The frame must be accepted, and a second frame to the same address must then be refused. Release of back-pressure is the other shared cycle. When `dec_ready` rises while a second descriptor waits, the stalled decision drains and the new one is captured on the same edge. The bench judges that case by the values held during the stall and by the second decision appearing one edge later.

// File: rtl/rx_addr_screen_pkg.sv
package rx_addr_screen_pkg;
  localparam int MAC_W   = 48;
  localparam int HASH_W  = 6;
  localparam int TBL_W   = 1 << HASH_W;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 16;
  localparam int MIN_LEN = 12;

  typedef enum logic [2:0] {
    SEL_ST0_LO = 3'd0,
    SEL_ST0_HI = 3'd1,
    SEL_ST1_LO = 3'd2,
    SEL_ST1_HI = 3'd3,
    SEL_TBL_LO = 3'd4,
    SEL_TBL_HI = 3'd5
  } cfg_sel_e;

  typedef struct packed {
    logic bcast_en;
    logic hash_indiv;
    logic st1_en;
    logic st0_en;
  } mode_t;
endpackage

// File: rtl/rx_addr_store.sv
module rx_addr_store
  import rx_addr_screen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [MAC_W-1:0]  st0,
  output logic [MAC_W-1:0]  st1,
  output logic [TBL_W-1:0]  tbl
);
  localparam int HI_W = MAC_W - WORD_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st0 <= '0;
      st1 <= '0;
      tbl <= '0;
    end else if (we) begin
      case (sel)
        SEL_ST0_LO: st0[WORD_W-1:0]     <= wdata;
        SEL_ST0_HI: st0[MAC_W-1:WORD_W] <= wdata[HI_W-1:0];
        SEL_ST1_LO: st1[WORD_W-1:0]     <= wdata;
        SEL_ST1_HI: st1[MAC_W-1:WORD_W] <= wdata[HI_W-1:0];
        SEL_TBL_LO: tbl[WORD_W-1:0]     <= wdata;
        SEL_TBL_HI: tbl[TBL_W-1:WORD_W] <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_hash_fold.sv
module rx_hash_fold #(
  parameter int IN_W  = 48,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] hash
);
  localparam int GROUPS = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PAD_W  = GROUPS * OUT_W;

  logic [PAD_W-1:0] padded;
  logic [OUT_W-1:0] part [GROUPS+1];

  assign padded  = PAD_W'(din);
  assign part[0] = '0;

  for (genvar g = 0; g < GROUPS; g++) begin : g_fold
    assign part[g+1] = part[g] ^ padded[g*OUT_W +: OUT_W];
  end

  assign hash = part[GROUPS];
endmodule

// File: rtl/rx_match_eval.sv
module rx_match_eval
  import rx_addr_screen_pkg::*;
(
  input  mode_t             mode,
  input  logic [MAC_W-1:0]  dest,
  input  logic [LEN_W-1:0]  len,
  input  logic [MAC_W-1:0]  st0,
  input  logic [MAC_W-1:0]  st1,
  input  logic [TBL_W-1:0]  tbl,
  input  logic [HASH_W-1:0] hash,
  output logic              accept
);
  logic long_enough, hit0, hit1, hit_bc, hash_ok, hit_grp;

  always_comb begin
    long_enough = (len >= LEN_W'(MIN_LEN));
    hit0        = mode.st0_en && (dest == st0);
    hit1        = mode.st1_en && (dest == st1);
    hit_bc      = mode.bcast_en && (&dest);
    hash_ok     = mode.hash_indiv || dest[0];
    hit_grp     = hash_ok && tbl[hash];
    accept      = long_enough && (hit0 || hit1 || hit_bc || hit_grp);
  end
endmodule

// File: rtl/rx_addr_screen.sv
module rx_addr_screen
  import rx_addr_screen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [MAC_W-1:0]  frm_dest,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_accept,
  output logic [HASH_W-1:0] dec_hash
);
  logic [MAC_W-1:0]  st0, st1;
  logic [TBL_W-1:0]  tbl;
  logic [HASH_W-1:0] hash_c;
  logic              accept_c;
  logic              take;

  rx_addr_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .st0   (st0),
    .st1   (st1),
    .tbl   (tbl)
  );

  rx_hash_fold #(.IN_W(MAC_W), .OUT_W(HASH_W)) u_fold (
    .din  (frm_dest),
    .hash (hash_c)
  );

  rx_match_eval u_eval (
    .mode   (mode_t'(mode)),
    .dest   (frm_dest),
    .len    (frm_len),
    .st0    (st0),
    .st1    (st1),
    .tbl    (tbl),
    .hash   (hash_c),
    .accept (accept_c)
  );

  assign frm_ready = !dec_valid || dec_ready;
  assign take      = frm_valid && frm_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_hash   <= '0;
    end else if (take) begin
      dec_valid  <= 1'b1;
      dec_accept <= accept_c;
      dec_hash   <= hash_c;
    end else if (dec_ready) begin
      dec_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_addr_screen_chk.sv
module rx_addr_screen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  mode,
  input logic        frm_valid,
  input logic        frm_ready,
  input logic [47:0] frm_dest,
  input logic [15:0] frm_len,
  input logic        dec_valid,
  input logic        dec_ready,
  input logic        dec_accept,
  input logic [5:0]  dec_hash
);
  logic [5:0] ref_hash;
  logic       took;

  always_comb begin
    ref_hash = '0;
    for (int k = 0; k < 48; k++) ref_hash[k % 6] = ref_hash[k % 6] ^ frm_dest[k];
  end

  assign took = frm_valid && frm_ready;

  assert_take_gives_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> dec_valid);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_accept) && $stable(dec_hash)));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !frm_ready);

  assert_short_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (took && frm_len < 16'd12) |=> !dec_accept);

  assert_bcast_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (took && frm_len >= 16'd12 && mode[3] && (&frm_dest)) |=> dec_accept);

  assert_hash_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (dec_hash == $past(ref_hash)));
endmodule

bind rx_addr_screen rx_addr_screen_chk u_chk (.*);

// File: tb/tb_rx_addr_screen.sv
module tb_rx_addr_screen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [47:0] frm_dest = '0;
  logic [15:0] frm_len = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic        dec_accept;
  logic [5:0]  dec_hash;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side copy of the configuration contents
  logic [47:0] m_st0 = '0, m_st1 = '0;
  logic [63:0] m_tbl = '0;

  rx_addr_screen dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model_hash(input logic [47:0] d);
    logic [5:0] h = '0;
    for (int g = 0; g < 8; g++) h = h ^ d[g*6 +: 6];
    return h;
  endfunction

  function automatic logic model_accept(input logic [47:0] d, input logic [15:0] len,
                                        input logic [3:0] m);
    logic grp;
    if (len < 16'd12) return 1'b0;
    grp = (m[2] || d[0]) && m_tbl[model_hash(d)];
    return (m[0] && d == m_st0) || (m[1] && d == m_st1) || (m[3] && (&d)) || grp;
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_st0[31:0]  = data;
      3'd1: m_st0[47:32] = data[15:0];
      3'd2: m_st1[31:0]  = data;
      3'd3: m_st1[47:32] = data[15:0];
      3'd4: m_tbl[31:0]  = data;
      3'd5: m_tbl[63:32] = data;
      default: ;
    endcase
  endtask

  task automatic send(input string req, input logic [47:0] d, input logic [15:0] len,
                      input logic exp_acc);
    @(negedge clk);
    frm_valid = 1'b1; frm_dest = d; frm_len = len;
    @(negedge clk);
    frm_valid = 1'b0;
    chk({req, " valid"}, 64'(dec_valid), 64'd1);
    chk({req, " accept"}, 64'(dec_accept), 64'(exp_acc));
    chk({req, " hash"}, 64'(dec_hash), 64'(model_hash(d)));
  endtask

  localparam logic [47:0] ADDR0 = 48'h5544_3322_1102;
  localparam logic [47:0] ADDR1 = 48'hAABB_CCDD_EE08;

  task automatic t_reset();
    chk("R10 dec_valid after reset", 64'(dec_valid), 64'd0);
    chk("R9 frm_ready after reset", 64'(frm_ready), 64'd1);
    mode = 4'b0100;
    send("R10 empty table refuses", 48'h0123_4567_89AB, 16'd64, 1'b0);
    mode = 4'b0001;
    send("R10 station0 is zero", 48'h0, 16'd64, 1'b1);
  endtask

  task automatic t_stations();
    cfg_write(3'd0, ADDR0[31:0]);
    cfg_write(3'd1, {16'hFFFF, ADDR0[47:32]});
    cfg_write(3'd2, ADDR1[31:0]);
    cfg_write(3'd3, {16'h0000, ADDR1[47:32]});
    cfg_write(3'd6, 32'hFFFF_FFFF);
    mode = 4'b0011;
    send("R2 station0 hit", ADDR0, 16'd60, 1'b1);
    send("R3 station1 hit", ADDR1, 16'd60, 1'b1);
    send("R8 byte order miss", 48'h0211_2233_4455, 16'd60, 1'b0);
    mode = 4'b0010;
    send("R2 station0 disabled", ADDR0, 16'd60, 1'b0);
    mode = 4'b0001;
    send("R3 station1 disabled", ADDR1, 16'd60, 1'b0);
  endtask

  task automatic t_short();
    mode = 4'b1011;
    send("R1 length 11 refused", ADDR0, 16'd11, 1'b0);
    send("R1 length 0 bcast refused", 48'hFFFF_FFFF_FFFF, 16'd0, 1'b0);
    send("R1 length 12 passes", ADDR0, 16'd12, 1'b1);
  endtask

  task automatic t_bcast();
    mode = 4'b1000;
    send("R4 broadcast on", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b1);
    mode = 4'b0000;
    send("R4 broadcast off", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0);
  endtask

  task automatic t_table();
    logic [47:0] d;
    mode = 4'b0000;
    cfg_write(3'd4, 32'hFFFF_FFFF);
    cfg_write(3'd5, 32'h0000_0000);
    for (int i = 0; i < 12; i++) begin
      d = {8'(i * 37), 8'(i * 91), 8'(i + 5), 8'(i * 13), 8'(i * 7), 8'(i * 2 + 1)};
      send("R6 low word only", d, 16'd64, model_hash(d) < 6'd32);
    end
    cfg_write(3'd4, 32'h0000_0000);
    cfg_write(3'd5, 32'hFFFF_FFFF);
    for (int i = 0; i < 12; i++) begin
      d = {8'(i * 29), 8'(i * 3), 8'(i + 77), 8'(i * 55), 8'(i * 11), 8'(i * 6 + 1)};
      send("R6 high word only", d, 16'd64, model_hash(d) >= 6'd32);
    end
    // single bit: index 33 set, all-ones-except hits via exact hash
    d = 48'h0000_0000_0021; // fold = 6'b100001 = 33
    cfg_write(3'd4, 32'h0);
    cfg_write(3'd5, 32'h0000_0002);
    send("R5 known fold 33", d, 16'd64, 1'b1);
    cfg_write(3'd5, 32'h0000_0001);
    send("R6 neighbour bit 32 misses", d, 16'd64, 1'b0);
  endtask

  task automatic t_individual();
    logic [47:0] d;
    d = 48'h1234_5678_9A00; // multicast bit clear
    cfg_write(3'd4, 32'hFFFF_FFFF);
    cfg_write(3'd5, 32'hFFFF_FFFF);
    mode = 4'b0000;
    send("R7 individual not hashed", d, 16'd64, 1'b0);
    mode = 4'b0100;
    send("R7 individual hashed", d, 16'd64, 1'b1);
    send("R5 hash reported", 48'h0000_0000_0021, 16'd5, model_accept(48'h21, 16'd5, mode));
    cfg_write(3'd4, 32'h0);
    cfg_write(3'd5, 32'h0);
  endtask

  task automatic t_stall();
    logic [47:0] d2;
    d2 = 48'hFFFF_FFFF_FFFF;
    mode = 4'b0001;
    @(negedge clk);
    dec_ready = 1'b0;
    frm_valid = 1'b1; frm_dest = ADDR0; frm_len = 16'd64;
    @(negedge clk);
    frm_dest = d2;
    for (int c = 0; c < 3; c++) begin
      chk("R9 stall ready low", 64'(frm_ready), 64'd0);
      chk("R9 stall holds accept", 64'(dec_accept), 64'd1);
      chk("R9 stall holds hash", 64'(dec_hash), 64'(model_hash(ADDR0)));
      @(negedge clk);
    end
    dec_ready = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R9 second decision valid", 64'(dec_valid), 64'd1);
    chk("R9 second decision", 64'(dec_accept), 64'd0);
    chk("R9 second hash", 64'(dec_hash), 64'(model_hash(d2)));
    @(negedge clk);
    chk("R9 drained", 64'(dec_valid), 64'd0);
  endtask

  task automatic t_same_cycle();
    mode = 4'b0001;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'hDEAD_BEEF;
    frm_valid = 1'b1; frm_dest = ADDR0; frm_len = 16'd64;
    @(negedge clk);
    cfg_we = 1'b0; frm_valid = 1'b0;
    m_st0[31:0] = 32'hDEAD_BEEF;
    chk("R11 old contents used", 64'(dec_accept), 64'd1);
    send("R11 new contents after", ADDR0, 16'd64, 1'b0);
    send("R8 new low word", {ADDR0[47:32], 32'hDEAD_BEEF}, 16'd64, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stations();
        t_short();
        t_bcast();
        t_table();
        t_individual();
        t_stall();
        t_same_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule